// File: doc/BRIEF.md
# Multiplexed Expansion ROM Read Controller

This block reads single bytes from an external parallel boot ROM. The ROM shares one 8-bit bidirectional pin bus with its address holding latches. Board pull-down straps on that bus set the configuration. A fixed number of clocks after reset is released, the block samples the bus once and keeps the value until the next reset. Strap bits [3:1] give the ROM size, from 16 KB up to 1 MB or "absent". Strap bit [0] selects the slow access timing.

A read proceeds as follows:

- The requester presents an address under a valid/ready handshake.
- The block drives the address onto the bus one byte at a time. Each byte has its own one-clock latch strobe. Two bytes are sent for ROMs up to 64 KB and three for larger ones.
- The block then releases the bus and asserts the ROM output-enable and chip-enable.
- It waits the configured number of clocks, captures the byte on the bus and returns it with a one-cycle response pulse.

A request is answered at once with 0xFF and an error flag, without any bus activity, in two cases: no ROM is strapped, or the address lies beyond the strapped size. The block also drives the writable-bit mask of a 32-bit expansion ROM base register. It drives the per-bit pull-up enables as well, which are switched off for bus bits that were strapped low.

Top module: `xrom_bus_ctrl`

## Requirements
- R1: The bus is sampled once, at the STRAP_DLY-th rising clock edge after reset release, and the sampled strap is kept until reset; later bus values do not change size or timing. req_ready first rises one clock after that capture edge.
- R2: With code c = strap[3:1] below 7, the ROM holds 16 KB << c bytes and bar_size_mask has ones in bits 31 down to 14+c and zeros below; with c = 7 (or before capture) bar_size_mask is all zeros.
- R3: bus_pull_en is 8'hFF until the strap is captured; afterwards bit i equals strap bit i, so bits read low have their pull-up off.
- R4: In the first clock after an accepted in-range request, mem_bus_oe=1, mem_bus_o=addr[7:0] and hold_strb=3'b001. In the second clock, mem_bus_o=addr[15:8] with hold_strb=3'b010. When c is at least 3, a third clock follows with mem_bus_o={4'b0,addr[19:16]} and hold_strb=3'b100. At most one strobe is ever high.
- R5: After the address clocks, mem_bus_oe=0 while rom_oe_n=rom_ce_n=0 for BASE_WAIT clocks, or BASE_WAIT+SLOW_ADD clocks when strap[0] is 0; the bus is never driven while rom_oe_n is low.
- R6: The value of mem_bus_i at the clock edge that ends the last enable clock is returned on rsp_data with rsp_valid=1 and rsp_err=0 during the next clock, in which the enables are high again; rsp_valid lasts one clock.
- R7: With c = 7, an accepted request gives rsp_valid=1, rsp_data=8'hFF, rsp_err=1 in the next clock, with no strobe, no bus drive and no enable.
- R8: An accepted request whose address is at or above 16 KB << c is answered exactly as in R7.
- R9: req_ready is high only when the block is configured, idle and not showing a response; requests or address changes while it is low cause no activity and no response.
- R10: While idle, mem_bus_oe=0, hold_strb=0 and rom_oe_n=rom_ce_n=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_addr | input | ADDR_W | Byte address of the read |
| req_ready | output | 1 | Request accepted at this edge when valid |
| rsp_valid | output | 1 | One-clock response pulse |
| rsp_data | output | 8 | Byte read, or 0xFF on error |
| rsp_err | output | 1 | Request refused (no ROM or out of range) |
| mem_bus_i | input | 8 | Sampled value of the shared bus pins |
| mem_bus_o | output | 8 | Value driven onto the shared bus |
| mem_bus_oe | output | 1 | Bus output enable |
| bus_pull_en | output | 8 | Per-bit internal pull-up enable |
| hold_strb | output | 3 | Latch strobes for address bytes 0, 1, 2 |
| rom_oe_n | output | 1 | ROM output enable, active low |
| rom_ce_n | output | 1 | ROM chip enable, active low |
| bar_size_mask | output | BAR_W | Writable bits of the expansion ROM base register |

## Verification
The bench keeps ADDR_W=20, MIN_LOG2=14, BASE_WAIT=3 and SLOW_ADD=2, and shortens STRAP_DLY to 5 so that each strap setting is configured within a few clocks. Five reset runs with different straps are used, covering:

- absent ROM;
- 16 KB fast;
- 64 KB fast, the largest two-byte size;
- 128 KB slow, the smallest three-byte size;
- 1 MB slow.

Together these reach both address-byte counts, both wait lengths, the top and one-past-top address of each size, and a mask at both ends of its range. An external latch-and-ROM model returns address-dependent data, so wrong address bytes or strobes show up as wrong read data as well as at the pins.

// File: rtl/xrom_pkg.sv
package xrom_pkg;

    localparam int BYTE_W = 8;
    localparam logic [2:0] CODE_ABSENT = 3'b111;

    typedef enum logic [2:0] {
        ST_CFG,
        ST_IDLE,
        ST_ADR0,
        ST_ADR1,
        ST_ADR2,
        ST_DATA
    } xrom_state_e;

endpackage

// File: rtl/xrom_strap_cfg.sv
module xrom_strap_cfg
    import xrom_pkg::*;
#(
    parameter int STRAP_DLY = 16,
    parameter int MIN_LOG2  = 14,
    parameter int BAR_W     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] bus_in,
    output logic              cfg_done,
    output logic [BYTE_W-1:0] strap,
    output logic [2:0]        size_code,
    output logic              rom_none,
    output logic              slow,
    output logic              three_byte,
    output logic [BAR_W-1:0]  bar_mask
);

    localparam int CNT_W = $clog2(STRAP_DLY + 1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic              done;
        logic [BYTE_W-1:0] strap;
    } cfg_reg_t;

    cfg_reg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (!cfg_q.done) begin
            if (cfg_q.cnt == CNT_W'(STRAP_DLY - 1)) begin
                cfg_d.done  = 1'b1;
                cfg_d.strap = bus_in;
            end else begin
                cfg_d.cnt = cfg_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.cnt   <= '0;
            cfg_q.done  <= 1'b0;
            cfg_q.strap <= '1;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_done   = cfg_q.done;
    assign strap      = cfg_q.strap;
    assign size_code  = cfg_q.strap[3:1];
    assign rom_none   = (cfg_q.strap[3:1] == CODE_ABSENT);
    assign slow       = ~cfg_q.strap[0];
    assign three_byte = (MIN_LOG2 + int'(cfg_q.strap[3:1])) > 2 * BYTE_W;

    for (genvar i = 0; i < BAR_W; i++) begin : g_mask
        assign bar_mask[i] = !rom_none && (i >= MIN_LOG2 + int'(size_code));
    end

    // R1
    strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |=> (cfg_done && $stable(strap)));

    // R3
    pull_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_done |-> (strap == '1));

endmodule

// File: rtl/xrom_range_chk.sv
module xrom_range_chk #(
    parameter int ADDR_W   = 20,
    parameter int MIN_LOG2 = 14
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        size_code,
    input  logic              rom_none,
    output logic              reject
);

    logic [ADDR_W-1:0] over_bit;

    for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
        assign over_bit[i] = addr[i] && (i >= MIN_LOG2 + int'(size_code));
    end

    assign reject = rom_none || (|over_bit);

endmodule

// File: rtl/xrom_seq.sv
module xrom_seq
    import xrom_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int BASE_WAIT = 3,
    parameter int SLOW_ADD  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_done,
    input  logic              slow,
    input  logic              three_byte,
    input  logic              reject,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [BYTE_W-1:0] rsp_data,
    output logic              rsp_err,
    input  logic [BYTE_W-1:0] bus_in,
    output logic [BYTE_W-1:0] bus_out,
    output logic              bus_oe,
    output logic [2:0]        strb,
    output logic              oe_n,
    output logic              ce_n
);

    localparam int WAIT_MAX = BASE_WAIT + SLOW_ADD;
    localparam int WCNT_W   = $clog2(WAIT_MAX + 1);
    localparam int PAD_W    = 3 * BYTE_W;

    typedef struct packed {
        xrom_state_e       state;
        logic [ADDR_W-1:0] addr;
        logic [WCNT_W-1:0] wcnt;
        logic [BYTE_W-1:0] bus_out;
        logic              bus_oe;
        logic [2:0]        strb;
        logic              oe_n;
        logic              ce_n;
        logic              rv;
        logic [BYTE_W-1:0] rd;
        logic              re;
    } seq_reg_t;

    seq_reg_t s_d, s_q;
    logic [PAD_W-1:0] addr_pad;
    logic [WCNT_W-1:0] wait_load;

    always_comb begin
        addr_pad = '0;
        addr_pad[ADDR_W-1:0] = s_q.addr;
    end

    assign wait_load = slow ? WCNT_W'(WAIT_MAX - 1) : WCNT_W'(BASE_WAIT - 1);

    always_comb begin
        s_d    = s_q;
        s_d.rv = 1'b0;
        unique case (s_q.state)
            ST_CFG: begin
                if (cfg_done) s_d.state = ST_IDLE;
            end
            ST_IDLE: begin
                if (req_valid && !s_q.rv) begin
                    if (reject) begin
                        s_d.rv = 1'b1;
                        s_d.rd = '1;
                        s_d.re = 1'b1;
                    end else begin
                        s_d.state   = ST_ADR0;
                        s_d.addr    = req_addr;
                        s_d.bus_oe  = 1'b1;
                        s_d.bus_out = req_addr[BYTE_W-1:0];
                        s_d.strb    = 3'b001;
                    end
                end
            end
            ST_ADR0: begin
                s_d.state   = ST_ADR1;
                s_d.bus_out = addr_pad[2*BYTE_W-1:BYTE_W];
                s_d.strb    = 3'b010;
            end
            ST_ADR1: begin
                if (three_byte) begin
                    s_d.state   = ST_ADR2;
                    s_d.bus_out = addr_pad[3*BYTE_W-1:2*BYTE_W];
                    s_d.strb    = 3'b100;
                end else begin
                    s_d.state  = ST_DATA;
                    s_d.bus_oe = 1'b0;
                    s_d.strb   = 3'b000;
                    s_d.oe_n   = 1'b0;
                    s_d.ce_n   = 1'b0;
                    s_d.wcnt   = wait_load;
                end
            end
            ST_ADR2: begin
                s_d.state  = ST_DATA;
                s_d.bus_oe = 1'b0;
                s_d.strb   = 3'b000;
                s_d.oe_n   = 1'b0;
                s_d.ce_n   = 1'b0;
                s_d.wcnt   = wait_load;
            end
            ST_DATA: begin
                if (s_q.wcnt == '0) begin
                    s_d.state = ST_IDLE;
                    s_d.oe_n  = 1'b1;
                    s_d.ce_n  = 1'b1;
                    s_d.rv    = 1'b1;
                    s_d.rd    = bus_in;
                    s_d.re    = 1'b0;
                end else begin
                    s_d.wcnt = s_q.wcnt - WCNT_W'(1);
                end
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.state   <= ST_CFG;
            s_q.addr    <= '0;
            s_q.wcnt    <= '0;
            s_q.bus_out <= '0;
            s_q.bus_oe  <= 1'b0;
            s_q.strb    <= '0;
            s_q.oe_n    <= 1'b1;
            s_q.ce_n    <= 1'b1;
            s_q.rv      <= 1'b0;
            s_q.rd      <= '0;
            s_q.re      <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign req_ready = (s_q.state == ST_IDLE) && !s_q.rv;
    assign rsp_valid = s_q.rv;
    assign rsp_data  = s_q.rd;
    assign rsp_err   = s_q.re;
    assign bus_out   = s_q.bus_out;
    assign bus_oe    = s_q.bus_oe;
    assign strb      = s_q.strb;
    assign oe_n      = s_q.oe_n;
    assign ce_n      = s_q.ce_n;

    // R4
    strb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strb));

    // R4
    third_strb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strb[2] |-> three_byte);

    // R5
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_oe && !oe_n));

    // R6
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R7
    err_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (rsp_data == '1 && !bus_oe && strb == 3'b000));

    // R9
    start_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strb[0]) |-> $past(req_valid));

endmodule

// File: rtl/xrom_bus_ctrl.sv
module xrom_bus_ctrl
    import xrom_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int MIN_LOG2  = 14,
    parameter int STRAP_DLY = 16,
    parameter int BASE_WAIT = 3,
    parameter int SLOW_ADD  = 2,
    parameter int BAR_W     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [7:0]        rsp_data,
    output logic              rsp_err,
    input  logic [7:0]        mem_bus_i,
    output logic [7:0]        mem_bus_o,
    output logic              mem_bus_oe,
    output logic [7:0]        bus_pull_en,
    output logic [2:0]        hold_strb,
    output logic              rom_oe_n,
    output logic              rom_ce_n,
    output logic [BAR_W-1:0]  bar_size_mask
);

    logic              cfg_done;
    logic [BYTE_W-1:0] strap;
    logic [2:0]        size_code;
    logic              rom_none;
    logic              slow;
    logic              three_byte;
    logic              reject;

    xrom_strap_cfg #(
        .STRAP_DLY (STRAP_DLY),
        .MIN_LOG2  (MIN_LOG2),
        .BAR_W     (BAR_W)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_in     (mem_bus_i),
        .cfg_done   (cfg_done),
        .strap      (strap),
        .size_code  (size_code),
        .rom_none   (rom_none),
        .slow       (slow),
        .three_byte (three_byte),
        .bar_mask   (bar_size_mask)
    );

    xrom_range_chk #(
        .ADDR_W   (ADDR_W),
        .MIN_LOG2 (MIN_LOG2)
    ) u_range (
        .addr      (req_addr),
        .size_code (size_code),
        .rom_none  (rom_none),
        .reject    (reject)
    );

    xrom_seq #(
        .ADDR_W    (ADDR_W),
        .BASE_WAIT (BASE_WAIT),
        .SLOW_ADD  (SLOW_ADD)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_done   (cfg_done),
        .slow       (slow),
        .three_byte (three_byte),
        .reject     (reject),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .req_ready  (req_ready),
        .rsp_valid  (rsp_valid),
        .rsp_data   (rsp_data),
        .rsp_err    (rsp_err),
        .bus_in     (mem_bus_i),
        .bus_out    (mem_bus_o),
        .bus_oe     (mem_bus_oe),
        .strb       (hold_strb),
        .oe_n       (rom_oe_n),
        .ce_n       (rom_ce_n)
    );

    assign bus_pull_en = strap;

endmodule

// File: tb/test_xrom_bus_ctrl.sv
module test_xrom_bus_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 20;
    localparam int MIN_LOG2   = 14;
    localparam int STRAP_DLY  = 5;
    localparam int BASE_WAIT  = 3;
    localparam int SLOW_ADD   = 2;
    localparam int BAR_W      = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_ready;
    logic              rsp_valid;
    logic [7:0]        rsp_data;
    logic              rsp_err;
    logic [7:0]        mem_bus_i;
    logic [7:0]        mem_bus_o;
    logic              mem_bus_oe;
    logic [7:0]        bus_pull_en;
    logic [2:0]        hold_strb;
    logic              rom_oe_n;
    logic              rom_ce_n;
    logic [BAR_W-1:0]  bar_size_mask;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    xrom_bus_ctrl #(
        .ADDR_W(ADDR_W), .MIN_LOG2(MIN_LOG2), .STRAP_DLY(STRAP_DLY),
        .BASE_WAIT(BASE_WAIT), .SLOW_ADD(SLOW_ADD), .BAR_W(BAR_W)
    ) i_xrom_bus_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rsp_err(rsp_err), .mem_bus_i(mem_bus_i), .mem_bus_o(mem_bus_o),
        .mem_bus_oe(mem_bus_oe), .bus_pull_en(bus_pull_en), .hold_strb(hold_strb),
        .rom_oe_n(rom_oe_n), .rom_ce_n(rom_ce_n), .bar_size_mask(bar_size_mask)
    );

    // ---------------- board model: straps, holding latches, ROM ----------------
    logic [7:0] strap_pins = 8'hFF;
    logic [7:0] hold0 = '0, hold1 = '0, hold2 = '0;
    logic [7:0] model_strap = 8'hFF;
    int         rel_edges = 0;

    function automatic logic [7:0] rom_byte(input logic [19:0] a, input int lg);
        logic [19:0] m;
        m = a & ((20'd1 << lg) - 20'd1);
        return m[7:0] ^ m[15:8] ^ {m[19:16], m[19:16]} ^ 8'h3C;
    endfunction

    function automatic int cur_lg();
        return MIN_LOG2 + int'(model_strap[3:1]);
    endfunction

    assign mem_bus_i = (!rom_oe_n && !rom_ce_n)
                     ? rom_byte({hold2[3:0], hold1, hold0}, cur_lg()) : strap_pins;

    always @(posedge clk) begin
        if (hold_strb[0]) hold0 <= mem_bus_o;
        if (hold_strb[1]) hold1 <= mem_bus_o;
        if (hold_strb[2]) hold2 <= mem_bus_o;
        if (!rst_n) rel_edges <= 0;
        else begin
            if (rel_edges == STRAP_DLY - 1) model_strap <= strap_pins;
            rel_edges <= rel_edges + 1;
        end
    end

    // ---------------- reference model ----------------
    typedef struct packed {
        logic       ready;
        logic       oe;
        logic [7:0] bo;
        logic [2:0] strb;
        logic       rom_en;
        logic       rv;
        logic [7:0] rd;
        logic       re;
        logic [3:0] tag;
    } exp_t;

    exp_t exp_q[$];
    exp_t cur_e;
    exp_t tmp_e;

    function automatic string rq(input int n);
        case (n)
            1: return "R1";   2: return "R2";   3: return "R3";
            4: return "R4";   5: return "R5";   6: return "R6";
            7: return "R7";   8: return "R8";   9: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(input int r, input logic [31:0] act, input logic [31:0] expv,
                       input string what);
        n_tests++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h at %0t", rq(r), what, act, expv, $time);
        end
    endtask

    function automatic exp_t blank(input int tag);
        exp_t e;
        e = '0;
        e.tag = 4'(tag);
        return e;
    endfunction

    task automatic push_request(input logic [19:0] a);
        int lg;
        int n_wait;
        lg = MIN_LOG2 + int'(model_strap[3:1]);
        if (model_strap[3:1] == 3'b111 || (a >> lg) != 0) begin
            tmp_e = blank(model_strap[3:1] == 3'b111 ? 7 : 8);
            tmp_e.rv = 1; tmp_e.rd = 8'hFF; tmp_e.re = 1;
            exp_q.push_back(tmp_e);
        end else begin
            tmp_e = blank(4); tmp_e.oe = 1; tmp_e.bo = a[7:0];  tmp_e.strb = 3'b001;
            exp_q.push_back(tmp_e);
            tmp_e = blank(4); tmp_e.oe = 1; tmp_e.bo = a[15:8]; tmp_e.strb = 3'b010;
            exp_q.push_back(tmp_e);
            if (lg > 16) begin
                tmp_e = blank(4); tmp_e.oe = 1; tmp_e.bo = {4'h0, a[19:16]}; tmp_e.strb = 3'b100;
                exp_q.push_back(tmp_e);
            end
            n_wait = BASE_WAIT + (model_strap[0] ? 0 : SLOW_ADD);
            for (int k = 0; k < n_wait; k++) begin
                tmp_e = blank(5); tmp_e.rom_en = 1;
                exp_q.push_back(tmp_e);
            end
            tmp_e = blank(6); tmp_e.rv = 1; tmp_e.rd = rom_byte(a, lg); tmp_e.re = 0;
            exp_q.push_back(tmp_e);
        end
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            exp_q.delete();
        end else begin
            logic [7:0]  s_exp;
            logic [31:0] m_exp;
            bit cfg_ok;
            cfg_ok = rel_edges >= STRAP_DLY + 1;
            if (exp_q.size() > 0) cur_e = exp_q.pop_front();
            else begin cur_e = blank(10); cur_e.ready = cfg_ok; end
            chk(cfg_ok ? 9 : 1, 32'(req_ready), 32'(cur_e.ready), "req_ready");
            chk(cur_e.tag, 32'(mem_bus_oe), 32'(cur_e.oe), "mem_bus_oe");
            if (cur_e.oe) chk(4, 32'(mem_bus_o), 32'(cur_e.bo), "address byte");
            chk(cur_e.tag, 32'(hold_strb), 32'(cur_e.strb), "hold_strb");
            chk(cur_e.tag == 10 ? 10 : 5, 32'(rom_oe_n), 32'(!cur_e.rom_en), "rom_oe_n");
            chk(cur_e.tag == 10 ? 10 : 5, 32'(rom_ce_n), 32'(!cur_e.rom_en), "rom_ce_n");
            chk(cur_e.rv ? cur_e.tag : 9, 32'(rsp_valid), 32'(cur_e.rv), "rsp_valid");
            if (cur_e.rv) begin
                chk(cur_e.tag, 32'(rsp_data), 32'(cur_e.rd), "rsp_data");
                chk(cur_e.tag, 32'(rsp_err), 32'(cur_e.re), "rsp_err");
            end
            s_exp = (rel_edges >= STRAP_DLY) ? model_strap : 8'hFF;
            chk(3, 32'(bus_pull_en), 32'(s_exp), "bus_pull_en");
            m_exp = (s_exp[3:1] == 3'b111) ? 32'h0 : (32'hFFFF_FFFF << (MIN_LOG2 + int'(s_exp[3:1])));
            chk(2, bar_size_mask, m_exp, "bar_size_mask");
            if (cur_e.ready && req_valid) push_request(req_addr);
        end
    end

    // ---------------- stimulus ----------------
    task automatic do_reset(input logic [7:0] pins);
        @(negedge clk);
        rst_n = 1'b0; req_valid = 1'b0; strap_pins = pins;
        #1;
        // R10 / R1 / R3: reset state at the pins
        chk(1, 32'(req_ready), 32'h0, "ready in reset");
        chk(10, 32'(mem_bus_oe), 32'h0, "bus released in reset");
        chk(10, 32'(rom_oe_n), 32'h1, "oe_n in reset");
        chk(3, 32'(bus_pull_en), 32'hFF, "pulls in reset");
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        rst_n = 1'b1;
        repeat (STRAP_DLY + 3) @(posedge clk);
    endtask

    task automatic issue(input logic [19:0] a, input int poke);
        @(posedge clk); #1;
        req_valid = 1'b1; req_addr = a;
        do @(negedge clk); while (!req_ready);
        @(posedge clk); #1;
        if (poke > 0) begin
            req_addr = ~a;              // R9: must be ignored while busy
            repeat (poke) @(posedge clk);
            #1;
        end
        req_valid = 1'b0;
        do @(negedge clk); while (!rsp_valid);
    endtask

    initial begin
        // 128 KB, slow: strap nibble 0110
        do_reset(8'hF6);
        issue(20'h12345, 3);
        issue(20'h000FF, 2);
        issue(20'h1FFFF, 0);
        issue(20'h20000, 0);        // R8 first address past 128 KB
        strap_pins = 8'h00;         // R1: later bus values must not reconfigure
        issue(20'h0ABCD, 3);
        strap_pins = 8'hF6;
        // absent ROM
        do_reset(8'hFF);
        issue(20'h00000, 0);        // R7
        issue(20'h00010, 0);
        // 16 KB, fast: nibble 0001
        do_reset(8'hF1);
        issue(20'h03FFF, 2);
        issue(20'h04000, 0);        // R8
        // back-to-back with valid held high (R9)
        @(posedge clk); #1;
        req_valid = 1'b1; req_addr = 20'h01234;
        do @(negedge clk); while (!req_ready);
        @(posedge clk); #1;
        req_addr = 20'h02345;
        do @(negedge clk); while (!req_ready);
        @(posedge clk); #1;
        req_valid = 1'b0;
        do @(negedge clk); while (!rsp_valid);
        // 64 KB, fast: nibble 0101, largest two-byte size
        do_reset(8'hE5);
        issue(20'h0FFFF, 3);
        issue(20'h10000, 0);        // R8
        // 1 MB, slow: nibble 1100, upper pulls partly off
        do_reset(8'h3C);
        issue(20'hFFFFF, 3);
        issue(20'h80001, 1);
        repeat (5) @(posedge clk);
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            finished = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule